// File: doc/BRIEF.md
# Idle-State Auto-Demotion Filter

This block sits between each core's idle-state request and the idle state that the power controller is allowed to act on. Every core presents a request code and an entry strobe when it goes idle, and a wake strobe when it resumes. For each entry the filter either grants the requested state or demotes it to a shallower one. The choice rests only on how long that same core stayed idle in its most recent idle period. The filter holds the granted code and a demotion flag for as long as the core is idle, and returns to the active code on wake.

There are two demotion paths, each with its own enable bit: a medium path that turns deep requests (C6/C7) into C3, and a shallow path that turns C3, C6 and C7 requests into C1. A shared configuration register holds both enables and a residency threshold in cycles. It comes out of reset with both paths off. Each core counts the cycles of its current idle period. When the period ends, the core records whether the count reached the threshold. Deep requests are demoted until an idle period reaches the threshold; after that they are granted as requested.

Top module: `idle_demote_filter`

## Requirements
- R1: After reset every core's granted code is C0 (3'd0), every demoted flag is 0, and both demotion paths are off, so a deep request is granted as requested until the configuration register is written.
- R2: State codes are 3 bits: C0=0, C1=1, C3=3, C6=6, C7=7. An entry strobe carrying C0 or any other code (2, 4, 5) is ignored, and the core stays active with grant C0.
- R3: A C1 request is always granted as C1 with the demoted flag at 0, whatever the configuration and history.
- R4: A C7 request that is not demoted is granted as C6 with the demoted flag at 0.
- R5: With only the medium path on (cfg_en bit 0), a C6 or C7 request with insufficient history is granted as C3 with the flag set, and a C3 request is granted as C3.
- R6: With only the shallow path on (cfg_en bit 1), a C3, C6 or C7 request with insufficient history is granted as C1 with the flag set.
- R7: With both paths on and insufficient history, a C3, C6 or C7 request is granted as C1.
- R8: Residency is the number of clock cycles the granted code is non-C0. A period whose residency is at least cfg_thr marks the history as sufficient, and the next deep request is then granted without demotion.
- R9: A period that ends with residency below cfg_thr clears the sufficient mark, so demotion resumes on the next request.
- R10: Each core's history and grant depend only on that core's own strobes.
- R11: When wake and entry arrive in the same cycle on an idle core, the ending period updates the history first, and the new request is decided with that updated history. The new state is granted in the next cycle.
- R12: An entry strobe on a core that is already idle is ignored. A wake strobe on an active core is ignored and leaves the history unchanged.
- R13: A write on cfg_we loads cfg_en and cfg_thr. The new values govern entries from the next cycle on, and the grant appears one cycle after the entry strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 2 | Path enables: bit 0 demote to C3, bit 1 demote to C1 |
| cfg_thr | input | CNT_W | Residency threshold in cycles |
| idle_entry | input | N_CORES | Per-core idle entry strobe |
| idle_req | input | 3*N_CORES | Per-core requested code, core i in bits 3i+2:3i |
| idle_wake | input | N_CORES | Per-core wake strobe |
| grant_code | output | 3*N_CORES | Per-core granted code, C0 while active |
| demoted | output | N_CORES | Per-core flag: grant is shallower than the request |

## Verification
The end of one idle period and the decision for the next can fall in the same cycle. The history written by the closing period must be the history that judges the new request. The bench provokes this by raising wake and entry together on an idle core, once after a period long enough to pass the threshold and once after a one-cycle period. It expects an undemoted C6 in the first case and a C1 demotion in the second. A stale history bit would swap these two outcomes.

// File: rtl/idle_demote_pkg.sv
`timescale 1ns/1ps
// Shared state codes and the demotion decision.
// Assumes 3-bit codes; only C1, C3, C6, C7 are valid idle requests.
package idle_demote_pkg;
    localparam logic [2:0] ST_C0 = 3'd0;
    localparam logic [2:0] ST_C1 = 3'd1;
    localparam logic [2:0] ST_C3 = 3'd3;
    localparam logic [2:0] ST_C6 = 3'd6;
    localparam logic [2:0] ST_C7 = 3'd7;

    typedef struct packed {
        logic [2:0] code;
        logic       dem;
    } grant_t;

    // True for codes that open an idle period.
    function automatic logic is_idle_code(input logic [2:0] c);
        return (c == ST_C1) || (c == ST_C3) || (c == ST_C6) || (c == ST_C7);
    endfunction

    // Picks the granted state; the shallow path wins when both are on.
    function automatic grant_t decide(input logic [2:0] req,
                                      input logic [1:0] en,
                                      input logic       hist_ok);
        grant_t     g;
        logic [2:0] base;
        base  = (req == ST_C7) ? ST_C6 : req;
        g.code = base;
        g.dem  = 1'b0;
        if (!hist_ok && base != ST_C1) begin
            if (en[1]) begin
                g.code = ST_C1;
                g.dem  = 1'b1;
            end else if (en[0] && base == ST_C6) begin
                g.code = ST_C3;
                g.dem  = 1'b1;
            end
        end
        return g;
    endfunction
endpackage

// File: rtl/idle_demote_cfg.sv
`timescale 1ns/1ps
// Holds the demotion enables and the residency threshold.
// Assumes software writes whole words; enables come out of reset cleared.
module idle_demote_cfg #(
    parameter int          CNT_W   = 8,
    parameter logic [CNT_W-1:0] THR_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       wr_en,
    input  logic [CNT_W-1:0] wr_thr,
    output logic [1:0]       en_q,
    output logic [CNT_W-1:0] thr_q
);
    // Configuration register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 2'b00;
            thr_q <= THR_RST;
        end else if (we) begin
            en_q  <= wr_en;
            thr_q <= wr_thr;
        end
    end

    // R1
    en_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we) |-> $stable(en_q));
endmodule

// File: rtl/idle_demote_core.sv
`timescale 1ns/1ps
// One core's filter: tracks the current idle period, counts its residency,
// keeps the sufficient-history bit and decides each new grant.
// Assumes entry and wake are single-cycle strobes synchronous to clk.
module idle_demote_core
    import idle_demote_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       en,
    input  logic [CNT_W-1:0] thr,
    input  logic             entry,
    input  logic [2:0]       req,
    input  logic             wake,
    output logic [2:0]       grant,
    output logic             demoted
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             idle_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hist_q;
    logic             period_end;
    logic             hist_nxt;
    logic             accept;
    grant_t           pick;

    // Closing period result is forwarded into the same-cycle decision.
    always_comb begin
        period_end = idle_q && wake;
        hist_nxt   = period_end ? (cnt_q >= thr) : hist_q;
        accept     = entry && is_idle_code(req) && (!idle_q || period_end);
        pick       = decide(req, en, hist_nxt);
    end

    // Period tracking, residency counting and grant register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q  <= 1'b0;
            cnt_q   <= '0;
            hist_q  <= 1'b0;
            grant   <= ST_C0;
            demoted <= 1'b0;
        end else begin
            hist_q <= hist_nxt;
            if (accept) begin
                idle_q  <= 1'b1;
                cnt_q   <= CNT_ONE;
                grant   <= pick.code;
                demoted <= pick.dem;
            end else if (period_end) begin
                idle_q  <= 1'b0;
                grant   <= ST_C0;
                demoted <= 1'b0;
            end else if (idle_q && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + CNT_ONE;
            end
        end
    end

    // R2
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == ST_C0) == !idle_q);
    // R3
    c1_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req == ST_C1) |=> (grant == ST_C1 && !demoted));
    // R1
    dem_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(demoted) |-> ($past(en) != 2'b00));
    // R12
    no_wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_q && !entry) |=> (grant == ST_C0 && $stable(hist_q)));
    // R5
    dem_shallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        demoted |-> (grant == ST_C1 || grant == ST_C3));
    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q && !wake && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/idle_demote_filter.sv
`timescale 1ns/1ps
// Top: one shared configuration register and one filter per core.
// Assumes per-core request codes are packed 3 bits per core, core 0 lowest.
module idle_demote_filter #(
    parameter int N_CORES = 2,
    parameter int CNT_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_en,
    input  logic [CNT_W-1:0]     cfg_thr,
    input  logic [N_CORES-1:0]   idle_entry,
    input  logic [3*N_CORES-1:0] idle_req,
    input  logic [N_CORES-1:0]   idle_wake,
    output logic [3*N_CORES-1:0] grant_code,
    output logic [N_CORES-1:0]   demoted
);
    logic [1:0]       en_q;
    logic [CNT_W-1:0] thr_q;

    idle_demote_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wr_en  (cfg_en),
        .wr_thr (cfg_thr),
        .en_q   (en_q),
        .thr_q  (thr_q)
    );

    // One independent filter per core.
    for (genvar i = 0; i < N_CORES; i++) begin : g_core
        idle_demote_core #(.CNT_W(CNT_W)) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_q),
            .thr     (thr_q),
            .entry   (idle_entry[i]),
            .req     (idle_req[3*i +: 3]),
            .wake    (idle_wake[i]),
            .grant   (grant_code[3*i +: 3]),
            .demoted (demoted[i])
        );
    end
endmodule

// File: tb/sim_idle_demote_filter.sv
`timescale 1ns/1ps
module sim_idle_demote_filter;
    localparam int N = 2;
    localparam int W = 8;
    localparam logic [2:0] C0 = 3'd0, C1 = 3'd1, C3 = 3'd3, C6 = 3'd6, C7 = 3'd7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_en = 2'b00;
    logic [W-1:0]   cfg_thr = '0;
    logic [N-1:0]   idle_entry = '0;
    logic [3*N-1:0] idle_req = '0;
    logic [N-1:0]   idle_wake = '0;
    logic [3*N-1:0] grant_code;
    logic [N-1:0]   demoted;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    idle_demote_filter #(.N_CORES(N), .CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
        .cfg_thr(cfg_thr), .idle_entry(idle_entry), .idle_req(idle_req),
        .idle_wake(idle_wake), .grant_code(grant_code), .demoted(demoted)
    );

    // vector: {en[1:0], period[7:0], req[2:0], exp_grant[2:0], exp_dem}
    localparam int NV = 12;
    localparam logic [16:0] VEC [NV] = '{
        {2'b01, 8'd2, C6, C3, 1'b1},   // R5
        {2'b01, 8'd2, C7, C3, 1'b1},   // R5
        {2'b01, 8'd2, C3, C3, 1'b0},   // R5
        {2'b10, 8'd2, C3, C1, 1'b1},   // R6
        {2'b10, 8'd2, C7, C1, 1'b1},   // R6
        {2'b11, 8'd2, C6, C1, 1'b1},   // R7
        {2'b11, 8'd4, C6, C6, 1'b0},   // R8
        {2'b11, 8'd3, C7, C1, 1'b1},   // R9
        {2'b00, 8'd1, C7, C6, 1'b0},   // R4
        {2'b11, 8'd1, C1, C1, 1'b0},   // R3
        {2'b11, 8'd9, C7, C6, 1'b0},   // R8
        {2'b01, 8'd4, C3, C3, 1'b0}    // R13
    };

    task automatic check(input string rq, input int c,
                         input logic [2:0] eg, input logic ed);
        n_chk++;
        if (grant_code[3*c +: 3] !== eg || demoted[c] !== ed) begin
            n_bad++;
            $display("FAIL %s core%0d: grant=%0d dem=%0b expected grant=%0d dem=%0b",
                     rq, c, grant_code[3*c +: 3], demoted[c], eg, ed);
        end
    endtask

    task automatic write_cfg(input logic [1:0] en, input logic [W-1:0] thr);
        cfg_we = 1'b1; cfg_en = en; cfg_thr = thr;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic enter(input int c, input logic [2:0] code);
        idle_entry[c] = 1'b1; idle_req[3*c +: 3] = code;
        @(negedge clk);
        idle_entry[c] = 1'b0;
    endtask

    task automatic wake_up(input int c);
        idle_wake[c] = 1'b1;
        @(negedge clk);
        idle_wake[c] = 1'b0;
    endtask

    // Idle period of d cycles in C1, which is never demoted.
    task automatic prime(input int c, input int d);
        enter(c, C1);
        repeat (d - 1) @(negedge clk);
        wake_up(c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", 0, C0, 1'b0);
        check("R1 reset", 1, C0, 1'b0);

        // R1: paths off after reset, short history still grants deep state
        prime(0, 1);
        enter(0, C6);
        check("R1 disabled", 0, C6, 1'b0);
        wake_up(0);

        // R2: C0 and unused codes ignored
        enter(0, C0);
        check("R2 C0", 0, C0, 1'b0);
        enter(0, 3'd5);
        check("R2 code5", 0, C0, 1'b0);

        // Table walk (R3..R9, R13)
        for (int v = 0; v < NV; v++) begin
            write_cfg(VEC[v][16:15], 8'd4);
            prime(0, int'(VEC[v][14:7]));
            enter(0, VEC[v][6:4]);
            check($sformatf("R3-9/R13 vec%0d", v), 0, VEC[v][3:1], VEC[v][0]);
            wake_up(0);
            check("R13 back to C0", 0, C0, 1'b0);
        end

        // R9: sufficient then short period clears the mark
        write_cfg(2'b01, 8'd4);
        prime(0, 6);
        enter(0, C6);
        check("R9 pass", 0, C6, 1'b0);
        wake_up(0);
        enter(0, C6);
        check("R9 cleared", 0, C3, 1'b1);
        wake_up(0);

        // R12: entry while idle ignored; wake while active ignored
        write_cfg(2'b11, 8'd4);
        prime(0, 5);
        wake_up(0);
        check("R12 stray wake", 0, C0, 1'b0);
        enter(0, C6);
        check("R12 history kept", 0, C6, 1'b0);
        enter(0, C3);
        check("R12 entry while idle", 0, C6, 1'b0);
        wake_up(0);

        // R10: cores keep separate histories
        write_cfg(2'b10, 8'd4);
        prime(1, 6);
        prime(0, 2);
        enter(0, C6);
        check("R10 core0", 0, C1, 1'b1);
        check("R10 core1 idle", 1, C0, 1'b0);
        enter(1, C6);
        check("R10 core1", 1, C6, 1'b0);
        wake_up(0);
        wake_up(1);

        // R11: wake and entry in one cycle use the updated history
        write_cfg(2'b11, 8'd4);
        prime(0, 1);
        enter(0, C1);
        repeat (4) @(negedge clk);
        idle_wake[0] = 1'b1; idle_entry[0] = 1'b1; idle_req[2:0] = C6;
        @(negedge clk);
        idle_wake[0] = 1'b0; idle_entry[0] = 1'b0;
        check("R11 long then C6", 0, C6, 1'b0);
        idle_wake[0] = 1'b1; idle_entry[0] = 1'b1; idle_req[2:0] = C6;
        @(negedge clk);
        idle_wake[0] = 1'b0; idle_entry[0] = 1'b0;
        check("R11 short then C6", 0, C1, 1'b1);
        wake_up(0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule